// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block sits on the outbound side of a system-bus-to-PCIe bridge. Software programs a small table of windows through a register port. Each window has a source base, a size code, an enable bit, a translated base and a route bit. Every address presented on the lookup port is compared against all enabled windows in parallel. The winning window swaps the address bits above the window size for its translated base. The result is tagged for either the memory request path or the configuration request path.

When no window matches, the block raises a miss flag and selects neither path. The lookup result is registered, so it appears one clock after the request. The routing logic downstream takes the address, the path select and, for configuration requests, the bus and device/function fields decoded from the translated address.

A single inbound window register shares the register port. Its size field is brought out as a port.

Top module: `attTop`

## Requirements
- R1: After reset, every table word and the inbound register read as zero, and `outValid`, `outHit`, `outMiss`, `outSelMem`, `outSelCfg`, `outAddr`, `outCfgBus`, `outCfgDevFn` and `inWinSize` are all zero.
- R2: Entry i occupies register offsets 0x800 + 0x20·i. At +0x0 is the source word: bit 0 is the enable, bits [6:1] are the size code and bits [31:7] are the base. At +0x8 is the translated base. Both read back exactly as written.
- R3: Several register words are reserved. The upper-address words at +0x4 and +0xC of each entry, and the inbound upper word at 0x604, always read zero and ignore writes. At +0x10 only bit 0 is kept; bits [31:1] read zero.
- R4: Entry i matches address A when its enable bit is 1 and A agrees with the base in every bit at or above position code+1. Base bits [6:0] are taken as zero. A code of 31 or more covers the whole 32-bit space.
- R5: On a hit, `outAddr` is formed from two sources. Bits at or above code+1 come from the translated base of the winning entry. Bits below code+1 come from the lookup address.
- R6: On a hit, exactly one path is selected. Route bit 0 at +0x10 selects `outSelMem` and route bit 1 selects `outSelCfg`.
- R7: When several entries match, the lowest-numbered one wins, and its number is given on `outIdx`.
- R8: When no enabled entry matches, `outMiss` is 1, `outHit`, `outSelMem` and `outSelCfg` are 0, and `outAddr` is 0.
- R9: A lookup presented with `lookupValid` at one clock edge produces its result after that edge. `outValid` is then 1, and exactly one of `outHit` and `outMiss` is 1. In a cycle after an edge without `lookupValid`, `outValid`, `outHit` and `outMiss` are all 0.
- R10: On a configuration-path hit, `outCfgBus` is `outAddr[27:20]` and `outCfgDevFn` is `outAddr[19:12]`. On any other result, both are zero.
- R11: The inbound register at 0x600 reads back as written, and `inWinSize` shows its bits [6:1]. A value of 0x1F stands for the full 32-bit space.
- R12: A disabled entry never matches, even when its base and size would cover the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset, used for both write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| lookupValid | input | 1 | Lookup request |
| lookupAddr | input | 32 | System-bus address to translate |
| outValid | output | 1 | Registered result valid |
| outHit | output | 1 | An enabled window matched |
| outMiss | output | 1 | No enabled window matched |
| outIdx | output | 3 | Number of the winning entry |
| outAddr | output | 32 | Translated PCIe address |
| outSelMem | output | 1 | Route the request to the memory path |
| outSelCfg | output | 1 | Route the request to the configuration path |
| outCfgBus | output | 8 | Bus number for configuration hits |
| outCfgDevFn | output | 8 | Device/function for configuration hits |
| inWinSize | output | 6 | Size field of the inbound window register |

## Verification
Directed lookups cover several distinct cases:
- two nested windows with different sizes, which separate the priority order from the size masking;
- a disabled entry sitting over an address, which separates the enable bit from the base comparison;
- a whole-space window, which checks the top size code;
- a configuration window, whose translated address must yield the expected bus and device/function fields.

Random lookups are aimed mostly inside programmed windows with random offsets and partly at arbitrary addresses, while entries are reprogrammed with random sizes, bases and routes. Together they test the bit boundary between substituted and passed-through address bits, and the line between hit and miss. Register writes to reserved words are followed by readback to show that nothing was stored.

// File: rtl/attPkg.sv
package attPkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int REG_AW = 12;
  localparam int NUM_ENTRIES = 8;
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int CODE_W = 6;
  localparam int PARAM_LSBS = CODE_W + 1;
  localparam int ENTRY_STRIDE_LOG2 = 5;
  localparam int TABLE_SPAN_LOG2 = IDX_W + ENTRY_STRIDE_LOG2;
  localparam int BUS_LSB = 20;
  localparam int DEVFN_LSB = 12;
  localparam int FLD_W = 8;

  localparam logic [REG_AW-1:0] TABLE_BASE = 12'h800;
  localparam logic [REG_AW-1:0] INWIN_LO = 12'h600;
  localparam logic [REG_AW-1:0] INWIN_HI = 12'h604;

  typedef enum logic [2:0] {
    FLD_SRC_LO, FLD_SRC_HI, FLD_TRSL_LO, FLD_TRSL_HI, FLD_ROUTE, FLD_NONE
  } fieldT;

  typedef struct packed {
    logic                   wrStrobe;
    logic [NUM_ENTRIES-1:0] entrySel;
    logic [IDX_W-1:0]       entryIdx;
    fieldT                  field;
    logic                   inWinSel;
    logic                   inWinHiSel;
  } regCtlT;

  // Offset mask: bit b belongs to the window offset when b <= code.
  function automatic logic [ADDR_W-1:0] winMask(input logic [CODE_W-1:0] code);
    for (int b = 0; b < ADDR_W; b++) winMask[b] = (b <= int'(code));
  endfunction
endpackage

// File: rtl/attCtrl.sv
module attCtrl
  import attPkg::*;
(
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output regCtlT            ctl
);
  logic             tableHit;
  logic [IDX_W-1:0] idx;

  assign tableHit = (regAddr[REG_AW-1:TABLE_SPAN_LOG2] ==
                     TABLE_BASE[REG_AW-1:TABLE_SPAN_LOG2]);
  assign idx = regAddr[TABLE_SPAN_LOG2-1:ENTRY_STRIDE_LOG2];

  always_comb begin
    ctl.wrStrobe   = regWrEn;
    ctl.entryIdx   = idx;
    ctl.entrySel   = tableHit ? (NUM_ENTRIES'(1) << idx) : '0;
    ctl.inWinSel   = (regAddr == INWIN_LO);
    ctl.inWinHiSel = (regAddr == INWIN_HI);
    ctl.field      = FLD_NONE;
    if (tableHit) begin
      unique case (regAddr[ENTRY_STRIDE_LOG2-1:0])
        5'h00:   ctl.field = FLD_SRC_LO;
        5'h04:   ctl.field = FLD_SRC_HI;
        5'h08:   ctl.field = FLD_TRSL_LO;
        5'h0C:   ctl.field = FLD_TRSL_HI;
        5'h10:   ctl.field = FLD_ROUTE;
        default: ctl.field = FLD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/attPath.sv
module attPath
  import attPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regCtlT            ctl,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              outValid,
  output logic              outHit,
  output logic              outMiss,
  output logic [IDX_W-1:0]  outIdx,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outSelMem,
  output logic              outSelCfg,
  output logic [FLD_W-1:0]  outCfgBus,
  output logic [FLD_W-1:0]  outCfgDevFn,
  output logic [CODE_W-1:0] inWinSize
);
  logic [DATA_W-1:0]      srcWord  [NUM_ENTRIES];
  logic [ADDR_W-1:0]      trslWord [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] cfgRoute;
  logic [ADDR_W-1:0]      xlat     [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [DATA_W-1:0]      inWinReg;
  logic [IDX_W-1:0]       winIdx;
  logic                   anyHit;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic [ADDR_W-1:0] offMask;
    logic [ADDR_W-1:0] baseAddr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcWord[g]  <= '0;
        trslWord[g] <= '0;
        cfgRoute[g] <= 1'b0;
      end else if (ctl.wrStrobe && ctl.entrySel[g]) begin
        case (ctl.field)
          FLD_SRC_LO:  srcWord[g]  <= regWrData;
          FLD_TRSL_LO: trslWord[g] <= regWrData;
          FLD_ROUTE:   cfgRoute[g] <= regWrData[0];
          default: ;
        endcase
      end
    end

    assign offMask   = winMask(srcWord[g][CODE_W:1]);
    assign baseAddr  = {srcWord[g][ADDR_W-1:PARAM_LSBS], {PARAM_LSBS{1'b0}}};
    assign hitVec[g] = srcWord[g][0] && (((lookupAddr ^ baseAddr) & ~offMask) == '0);
    assign xlat[g]   = (trslWord[g] & ~offMask) | (lookupAddr & offMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inWinReg <= '0;
    else if (ctl.wrStrobe && ctl.inWinSel) inWinReg <= regWrData;
  end
  assign inWinSize = inWinReg[CODE_W:1];

  always_comb begin
    regRdData = '0;
    if (ctl.inWinSel) regRdData = inWinReg;
    else if (|ctl.entrySel) begin
      case (ctl.field)
        FLD_SRC_LO:  regRdData = srcWord[ctl.entryIdx];
        FLD_TRSL_LO: regRdData = trslWord[ctl.entryIdx];
        FLD_ROUTE:   regRdData = DATA_W'(cfgRoute[ctl.entryIdx]);
        default:     regRdData = '0;
      endcase
    end
  end

  // Lowest index wins: scan downward so the last assignment is the smallest.
  always_comb begin
    winIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (hitVec[i]) winIdx = IDX_W'(i);
  end
  assign anyHit = |hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0; outHit <= 1'b0; outMiss <= 1'b0; outIdx <= '0;
      outAddr <= '0; outSelMem <= 1'b0; outSelCfg <= 1'b0;
    end else begin
      outValid  <= lookupValid;
      outHit    <= lookupValid && anyHit;
      outMiss   <= lookupValid && !anyHit;
      outIdx    <= (lookupValid && anyHit) ? winIdx : '0;
      outAddr   <= (lookupValid && anyHit) ? xlat[winIdx] : '0;
      outSelMem <= lookupValid && anyHit && !cfgRoute[winIdx];
      outSelCfg <= lookupValid && anyHit && cfgRoute[winIdx];
    end
  end

  assign outCfgBus   = outSelCfg ? outAddr[BUS_LSB+FLD_W-1:BUS_LSB] : '0;
  assign outCfgDevFn = outSelCfg ? outAddr[DEVFN_LSB+FLD_W-1:DEVFN_LSB] : '0;
endmodule

// File: rtl/attTop.sv
module attTop
  import attPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              outValid,
  output logic              outHit,
  output logic              outMiss,
  output logic [IDX_W-1:0]  outIdx,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outSelMem,
  output logic              outSelCfg,
  output logic [FLD_W-1:0]  outCfgBus,
  output logic [FLD_W-1:0]  outCfgDevFn,
  output logic [CODE_W-1:0] inWinSize
);
  regCtlT ctl;

  attCtrl u_ctrl (.regWrEn(regWrEn), .regAddr(regAddr), .ctl(ctl));

  attPath u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regWrData(regWrData), .regRdData(regRdData),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr), .outValid(outValid),
    .outHit(outHit), .outMiss(outMiss), .outIdx(outIdx), .outAddr(outAddr),
    .outSelMem(outSelMem), .outSelCfg(outSelCfg), .outCfgBus(outCfgBus),
    .outCfgDevFn(outCfgDevFn), .inWinSize(inWinSize)
  );
endmodule

// File: rtl/attChecker.sv
module attChecker
  import attPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [REG_AW-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              lookupValid,
  input logic              outValid,
  input logic              outHit,
  input logic              outMiss,
  input logic [ADDR_W-1:0] outAddr,
  input logic              outSelMem,
  input logic              outSelCfg,
  input logic [FLD_W-1:0]  outCfgBus,
  input logic [FLD_W-1:0]  outCfgDevFn,
  input logic [CODE_W-1:0] inWinSize
);
  a_r9_valid_after_req: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (outValid && (outHit != outMiss)));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> (!outValid && !outHit && !outMiss));
  a_r8_miss_no_route: assert property (@(posedge clk) disable iff (!rstN)
    outMiss |-> (!outSelMem && !outSelCfg && outAddr == '0 && !outHit));
  a_r6_single_route: assert property (@(posedge clk) disable iff (!rstN)
    outHit |-> ($countones({outSelMem, outSelCfg}) == 1));
  a_r10_fields_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outSelCfg |-> (outCfgBus == '0 && outCfgDevFn == '0));
  a_r3_inwin_hi_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == INWIN_HI) |-> (regRdData == '0));
  a_r11_size_port: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == INWIN_LO) |-> (regRdData[CODE_W:1] == inWinSize));
endmodule

bind attTop attChecker u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .lookupValid(lookupValid), .outValid(outValid), .outHit(outHit), .outMiss(outMiss),
  .outAddr(outAddr), .outSelMem(outSelMem), .outSelCfg(outSelCfg),
  .outCfgBus(outCfgBus), .outCfgDevFn(outCfgDevFn), .inWinSize(inWinSize)
);

// File: tb/test_attTop.sv
`timescale 1ns/1ps
module test_attTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic        outValid, outHit, outMiss, outSelMem, outSelCfg;
  logic [2:0]  outIdx;
  logic [31:0] outAddr;
  logic [7:0]  outCfgBus, outCfgDevFn;
  logic [5:0]  inWinSize;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  logic [31:0] mSrc [8];
  logic [31:0] mTrsl [8];
  logic        mCfg [8];

  always #2.5 clk = ~clk;

  attTop i_attTop (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] maskOf(input logic [5:0] code);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (b <= int'(code));
    return m;
  endfunction

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(regRdData == exp, req, regRdData, exp);
  endtask

  task automatic prog(input int i, input logic [31:0] src, input logic [31:0] trsl, input bit cfg);
    logic [11:0] b;
    b = 12'h800 + 12'(i * 32);
    wrReg(b, src);
    wrReg(b + 12'h8, trsl);
    wrReg(b + 12'h10, {31'b0, cfg});
    mSrc[i] = src; mTrsl[i] = trsl; mCfg[i] = cfg;
  endtask

  task automatic lookup(input logic [31:0] a, input string req);
    bit eHit; int eIdx; logic [31:0] eAddr, m; bit eCfg;
    eHit = 1'b0; eIdx = 0; eAddr = '0; eCfg = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      m = maskOf(mSrc[i][6:1]);
      if (mSrc[i][0] && (((a ^ {mSrc[i][31:7], 7'b0}) & ~m) == '0)) begin
        eHit = 1'b1; eIdx = i; eAddr = (mTrsl[i] & ~m) | (a & m); eCfg = mCfg[i];
      end
    end
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = a;
    @(negedge clk);
    lookupValid = 1'b0;
    chk(outValid && outHit == eHit && outMiss == !eHit, {req, " R9 hit/miss"},
        {29'b0, outValid, outHit, outMiss}, {29'b0, 1'b1, eHit, !eHit});
    if (eHit) begin
      chk(outIdx == 3'(eIdx), {req, " R7 index"}, 32'(outIdx), 32'(eIdx));
      chk(outAddr == eAddr, {req, " R5 address"}, outAddr, eAddr);
      chk(outSelCfg == eCfg && outSelMem == !eCfg, {req, " R6 route"},
          {30'b0, outSelCfg, outSelMem}, {30'b0, eCfg, !eCfg});
      chk({outCfgBus, outCfgDevFn} == (eCfg ? eAddr[27:12] : 16'h0), {req, " R10 fields"},
          {16'b0, outCfgBus, outCfgDevFn}, {16'b0, eCfg ? eAddr[27:12] : 16'h0});
    end else begin
      chk(outAddr == '0 && !outSelCfg && !outSelMem, {req, " R8 miss quiet"},
          outAddr, 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    int j;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin mSrc[i] = '0; mTrsl[i] = '0; mCfg[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!outValid && !outHit && !outMiss && outAddr == 0 && !outSelMem && !outSelCfg &&
        outCfgBus == 0 && outCfgDevFn == 0 && inWinSize == 0, "R1 outputs", outAddr, 32'h0);
    rdChk(12'h800, 32'h0, "R1 entry0 src");
    rdChk(12'h8E8, 32'h0, "R1 entry7 trsl");
    rdChk(12'h600, 32'h0, "R1 inbound");
    lookup(32'h1234_5678, "R1 empty table");

    // R11 inbound window
    wrReg(12'h600, 32'hABCD_E03E);
    rdChk(12'h600, 32'hABCD_E03E, "R11 readback");
    chk(inWinSize == 6'h1F, "R11 size port", 32'(inWinSize), 32'h1F);
    wrReg(12'h604, 32'hFFFF_FFFF);
    rdChk(12'h604, 32'h0, "R3 inbound upper");

    // Entry 0: configuration window, 256 MB at 0x4000_0000
    prog(0, 32'h4000_0000 | (32'd27 << 1) | 32'd1, 32'h0, 1'b1);
    rdChk(12'h800, 32'h4000_0037, "R2 src readback");
    rdChk(12'h808, 32'h0, "R2 trsl readback");
    lookup(32'h4123_4ABC, "R10 config hit");

    // R3 reserved words
    wrReg(12'h804, 32'hFFFF_FFFF);
    rdChk(12'h804, 32'h0, "R3 src upper");
    wrReg(12'h80C, 32'hFFFF_FFFF);
    rdChk(12'h80C, 32'h0, "R3 trsl upper");
    wrReg(12'h810, 32'hFFFF_FFFF);
    rdChk(12'h810, 32'h1, "R3 route bits");
    rdChk(12'h800, 32'h4000_0037, "R3 src untouched");

    // R7 nested windows
    prog(1, 32'h8000_0000 | (32'd19 << 1) | 32'd1, 32'h1000_0000, 1'b0);
    prog(2, 32'h8000_0000 | (32'd23 << 1) | 32'd1, 32'h2000_0000, 1'b0);
    rdChk(12'h828, 32'h1000_0000, "R2 entry1 trsl");
    lookup(32'h8001_2345, "R7 inner");
    chk(outIdx == 3'd1 && outAddr == 32'h1001_2345, "R7 directed", outAddr, 32'h1001_2345);
    lookup(32'h8050_0000, "R4 outer");
    chk(outIdx == 3'd2 && outAddr == 32'h2050_0000, "R4 directed", outAddr, 32'h2050_0000);

    // R12 disabled entry
    prog(3, 32'h9000_0000 | (32'd15 << 1), 32'h3000_0000, 1'b0);
    lookup(32'h9000_0010, "R12 disabled");
    chk(outMiss && !outHit, "R12 directed miss", {31'b0, outMiss}, 32'h1);
    @(negedge clk);
    chk(!outValid && !outHit && !outMiss, "R9 idle after lookup", {31'b0, outValid}, 32'h0);

    // R4 whole-space window
    prog(7, 32'h0000_0000 | (32'd31 << 1) | 32'd1, 32'h0, 1'b0);
    lookup(32'h9000_0010, "R4 whole space");
    chk(outIdx == 3'd7 && outAddr == 32'h9000_0010, "R4 whole directed", outAddr, 32'h9000_0010);

    // Random phase
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 6 == 0) begin
        j = 1 + int'($urandom % 7);
        prog(j, ($urandom & 32'hFFFF_FF80) | (32'(11 + $urandom % 14) << 1) |
                32'(($urandom % 4) != 0), $urandom, 1'($urandom));
      end
      j = int'($urandom % 8);
      if ($urandom % 4 == 0) a = $urandom;
      else a = {mSrc[j][31:7], 7'b0} ^ ($urandom & maskOf(mSrc[j][6:1]));
      lookup(a, "R5 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule